// File: doc/BRIEF.md
# Coarse Delay Search Controller

This controller moves a sync pulse in coarse steps until a single-photon event falls inside the receiver's detection window. It drives two cascaded programmable delay lines, each set by its own delay word. Every attempt begins with a photon event. The controller then waits a bounded number of cycles for the two per-channel "valid photon" flags that the receiver sends back. Each attempt ends as either a hit or a miss.

The decisions are statistical, so no single event moves the delay. A run of consecutive misses advances the delay by one step. The first line's word is raised until it reaches its ceiling, and after that the second line's word is raised. A run of consecutive hits ends the search with a done flag. If another step is needed while both words are already at their ceiling, the controller raises an error flag and stays stopped. Each time a new word is written, the controller lets the line settle before it accepts the next photon event. Fine alignment is handled by later logic.

Top module: `dls_coarse_search`

## Requirements
- R1: An attempt starts only when `init_done` is high and `photon_evt` is sampled high while the controller is idle. A photon event before init, during a listening window, during settling, after done or after error has no effect.
- R2: After an attempt starts, the controller listens for `WAIT_CYC` cycles (default 60). If the attempt does not qualify as a hit within that time, it counts as a miss.
- R3: An attempt is a hit only when `ok_a` and `ok_b` are sampled high in the same cycle of the window. An attempt in which only one flag is asserted counts as a miss.
- R4: After `RUN_LEN` consecutive hits (default 5), `done` goes high and stays high. After that, the delay words never change and no further attempts start.
- R5: After `RUN_LEN` consecutive misses, the delay advances by exactly one step. A hit clears the miss run and a miss clears the hit run, so only unbroken runs count.
- R6: A step raises `dly_a` by one while `dly_a` < `LIMIT` (default 255, i.e. 0x0FF). Otherwise it raises `dly_b` by one. The strobe of the word that changed (`ld_a` or `ld_b`) is high for exactly one cycle, in the first cycle in which the new value is visible.
- R7: If a step is due while both words equal `LIMIT`, `err` goes high and stays high. After that, the words are frozen and no further attempts start.
- R8: After each step, the controller ignores photon events for `SETTLE_CYC` cycles (default 3) before returning to idle.
- R9: A synchronous active-high `rst` returns the controller to idle. It clears both run counters, sets both words to zero, and drops `done`, `err` and both strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_done | input | 1 | High once upstream initialization has finished; enables the search |
| photon_evt | input | 1 | Photon event, starts an attempt when idle |
| ok_a | input | 1 | Valid-photon flag from receiver channel A |
| ok_b | input | 1 | Valid-photon flag from receiver channel B |
| dly_a | output | DW | Delay word of the first line |
| dly_b | output | DW | Delay word of the second line |
| ld_a | output | 1 | One-cycle latch strobe for `dly_a` |
| ld_b | output | 1 | One-cycle latch strobe for `dly_b` |
| done | output | 1 | Search finished with a stable hit run |
| err | output | 1 | Both lines exhausted without success |

## Verification
The assertions assume that `LIMIT` fits in `DW` bits and that the run and timer lengths are at least one. They also assume the words only ever move through the step path, so each strobe shows a single increment of its own word. Feedback flags are ignored outside a listening window. For that reason the stimulus raises them only one cycle after a photon pulse, and it keeps every photon pulse to a single cycle, so each intended attempt is sampled exactly once. The bench uses a small `LIMIT` and a short window, so that exhausting both lines and reaching the error state takes only a few hundred cycles.

// File: rtl/dls_pkg.sv
package dls_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LISTEN,
    ST_STEP,
    ST_SETTLE,
    ST_DONE,
    ST_ERROR
  } dls_state_t;
endpackage

// File: rtl/dls_streak.sv
// Counts an unbroken run of events; a clear breaks the run.
module dls_streak #(
  parameter int RUN_LEN = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic clr,
  output logic full
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

  logic [CW-1:0] cnt;

  assign full = inc && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr || full) cnt <= '0;
    else if (inc)           cnt <= cnt + 1'b1;
  end

  // R5: the run never passes its length
  assert_run_bound_R5: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/dls_timer.sv
// Counts cycles while run is high; last marks the final cycle.
module dls_timer #(
  parameter int LEN = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic last
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] END_V = CW'(LEN - 1);

  logic [CW-1:0] cnt;

  assign last = run && (cnt == END_V);

  always_ff @(posedge clk) begin
    if (rst || !run || last) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  // R2: the window counter stays inside its length
  assert_timer_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cnt <= END_V);
endmodule

// File: rtl/dls_delay_pair.sv
// Two cascaded delay words: the first fills before the second moves.
module dls_delay_pair #(
  parameter int DW    = 10,
  parameter int LIMIT = 255
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [DW-1:0] dly_a,
  output logic [DW-1:0] dly_b,
  output logic          ld_a,
  output logic          ld_b,
  output logic          exhausted
);
  localparam logic [DW-1:0] LIM = DW'(LIMIT);

  assign exhausted = (dly_a == LIM) && (dly_b == LIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      dly_a <= '0;
      dly_b <= '0;
      ld_a  <= 1'b0;
      ld_b  <= 1'b0;
    end else begin
      ld_a <= 1'b0;
      ld_b <= 1'b0;
      if (step) begin
        if (dly_a < LIM) begin
          dly_a <= dly_a + 1'b1;
          ld_a  <= 1'b1;
        end else if (dly_b < LIM) begin
          dly_b <= dly_b + 1'b1;
          ld_b  <= 1'b1;
        end
      end
    end
  end

  // R6: words stay within the ceiling
  assert_word_range_R6: assert property (@(posedge clk) disable iff (rst)
    (dly_a <= LIM) && (dly_b <= LIM));
  // R6: the second line moves only once the first is full
  assert_cascade_order_R6: assert property (@(posedge clk) disable iff (rst)
    ld_b |-> (dly_a == LIM));
  // R6: at most one strobe at a time
  assert_single_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    $countones({ld_a, ld_b}) <= 1);
  // R6: a strobe marks a one-step increase of its word
  assert_strobe_step_a_R6: assert property (@(posedge clk) disable iff (rst)
    ld_a |-> (dly_a == $past(dly_a) + 1'b1));
  assert_strobe_step_b_R6: assert property (@(posedge clk) disable iff (rst)
    ld_b |-> (dly_b == $past(dly_b) + 1'b1));
endmodule

// File: rtl/dls_coarse_search.sv
module dls_coarse_search #(
  parameter int DW         = 10,
  parameter int LIMIT      = 255,
  parameter int WAIT_CYC   = 60,
  parameter int RUN_LEN    = 5,
  parameter int SETTLE_CYC = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init_done,
  input  logic          photon_evt,
  input  logic          ok_a,
  input  logic          ok_b,
  output logic [DW-1:0] dly_a,
  output logic [DW-1:0] dly_b,
  output logic          ld_a,
  output logic          ld_b,
  output logic          done,
  output logic          err
);
  import dls_pkg::*;

  dls_state_t state, nxt;
  logic win_last, settle_last;
  logic hit_ev, miss_ev, hit_full, miss_full;
  logic exhausted, step;
  logic done_q, err_q;

  assign hit_ev  = (state == ST_LISTEN) && ok_a && ok_b;
  assign miss_ev = (state == ST_LISTEN) && !(ok_a && ok_b) && win_last;
  assign step    = (state == ST_STEP);

  dls_timer #(.LEN(WAIT_CYC)) u_win (
    .clk(clk), .rst(rst), .run(state == ST_LISTEN), .last(win_last));

  dls_timer #(.LEN(SETTLE_CYC)) u_settle (
    .clk(clk), .rst(rst), .run(state == ST_SETTLE), .last(settle_last));

  dls_streak #(.RUN_LEN(RUN_LEN)) u_hits (
    .clk(clk), .rst(rst), .inc(hit_ev), .clr(miss_ev), .full(hit_full));

  dls_streak #(.RUN_LEN(RUN_LEN)) u_miss (
    .clk(clk), .rst(rst), .inc(miss_ev), .clr(hit_ev), .full(miss_full));

  dls_delay_pair #(.DW(DW), .LIMIT(LIMIT)) u_dly (
    .clk(clk), .rst(rst), .step(step),
    .dly_a(dly_a), .dly_b(dly_b), .ld_a(ld_a), .ld_b(ld_b),
    .exhausted(exhausted));

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (init_done && photon_evt) nxt = ST_LISTEN;
      ST_LISTEN: begin
        if (hit_ev)       nxt = hit_full ? ST_DONE : ST_IDLE;
        else if (miss_ev) nxt = !miss_full ? ST_IDLE :
                                (exhausted ? ST_ERROR : ST_STEP);
      end
      ST_STEP:   nxt = ST_SETTLE;
      ST_SETTLE: if (settle_last) nxt = ST_IDLE;
      ST_DONE:   nxt = ST_DONE;
      ST_ERROR:  nxt = ST_ERROR;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      state  <= nxt;
      done_q <= (nxt == ST_DONE);
      err_q  <= (nxt == ST_ERROR);
    end
  end

  assign done = done_q;
  assign err  = err_q;

  // R9: reset leaves every output cleared
  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (dly_a == '0 && dly_b == '0 && !done && !err && !ld_a && !ld_b));
  // R4: done is sticky and freezes the words
  assert_done_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && $stable(dly_a) && $stable(dly_b)));
  // R7: error is sticky and freezes the words
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    err |=> (err && $stable(dly_a) && $stable(dly_b)));
  assert_done_err_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(done && err));
  // R8: a fresh word is followed by settling, not listening
  assert_settle_after_step_R8: assert property (@(posedge clk) disable iff (rst)
    (ld_a || ld_b) |-> (state == ST_SETTLE));
  // R1: listening begins only from idle with init done
  assert_start_gate_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(state == ST_LISTEN) |-> ($past(state) == ST_IDLE && $past(init_done)));
endmodule

// File: tb/sim_dls_coarse_search.sv
`timescale 1ns/1ps
module sim_dls_coarse_search;
  localparam int DW = 10, LIMIT = 2, WAIT_CYC = 8, RUN_LEN = 5, SETTLE_CYC = 3;
  localparam int GAP = WAIT_CYC + SETTLE_CYC + 6;
  localparam int NV = 30;
  // kind: 0 miss (no flags), 1 hit (both flags), 2 partial (ok_a only)
  // fields: [23:22] kind, [21:12] exp dly_a, [11:2] exp dly_b, [1] done, [0] err
  localparam logic [23:0] VEC [NV] = '{
    {2'd0,10'd0,10'd0,1'b0,1'b0}, {2'd0,10'd0,10'd0,1'b0,1'b0},
    {2'd0,10'd0,10'd0,1'b0,1'b0}, {2'd0,10'd0,10'd0,1'b0,1'b0},
    {2'd1,10'd0,10'd0,1'b0,1'b0}, {2'd0,10'd0,10'd0,1'b0,1'b0},
    {2'd0,10'd0,10'd0,1'b0,1'b0}, {2'd0,10'd0,10'd0,1'b0,1'b0},
    {2'd0,10'd0,10'd0,1'b0,1'b0}, {2'd0,10'd1,10'd0,1'b0,1'b0},
    {2'd0,10'd1,10'd0,1'b0,1'b0}, {2'd2,10'd1,10'd0,1'b0,1'b0},
    {2'd0,10'd1,10'd0,1'b0,1'b0}, {2'd2,10'd1,10'd0,1'b0,1'b0},
    {2'd0,10'd2,10'd0,1'b0,1'b0}, {2'd0,10'd2,10'd0,1'b0,1'b0},
    {2'd0,10'd2,10'd0,1'b0,1'b0}, {2'd0,10'd2,10'd0,1'b0,1'b0},
    {2'd0,10'd2,10'd0,1'b0,1'b0}, {2'd0,10'd2,10'd1,1'b0,1'b0},
    {2'd0,10'd2,10'd1,1'b0,1'b0}, {2'd0,10'd2,10'd1,1'b0,1'b0},
    {2'd0,10'd2,10'd1,1'b0,1'b0}, {2'd0,10'd2,10'd1,1'b0,1'b0},
    {2'd0,10'd2,10'd2,1'b0,1'b0}, {2'd0,10'd2,10'd2,1'b0,1'b0},
    {2'd0,10'd2,10'd2,1'b0,1'b0}, {2'd0,10'd2,10'd2,1'b0,1'b0},
    {2'd0,10'd2,10'd2,1'b0,1'b0}, {2'd0,10'd2,10'd2,1'b0,1'b1}
  };

  logic clk = 0, rst = 1, init_done = 0, photon_evt = 0, ok_a = 0, ok_b = 0;
  logic [DW-1:0] dly_a, dly_b;
  logic ld_a, ld_b, done, err;
  int checks = 0, errors = 0, n_lda = 0, n_ldb = 0;

  always #5 clk = ~clk;

  dls_coarse_search #(.DW(DW), .LIMIT(LIMIT), .WAIT_CYC(WAIT_CYC),
    .RUN_LEN(RUN_LEN), .SETTLE_CYC(SETTLE_CYC)) u0 (
    .clk(clk), .rst(rst), .init_done(init_done), .photon_evt(photon_evt),
    .ok_a(ok_a), .ok_b(ok_b), .dly_a(dly_a), .dly_b(dly_b),
    .ld_a(ld_a), .ld_b(ld_b), .done(done), .err(err));

  always @(negedge clk) begin
    if (ld_a) n_lda++;
    if (ld_b) n_ldb++;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_state(string req, int a, int b, int d, int e);
    chk({req, " dly_a"}, dly_a, a);
    chk({req, " dly_b"}, dly_b, b);
    chk({req, " done"}, done, d);
    chk({req, " err"}, err, e);
  endtask

  task automatic attempt(int kind);
    @(negedge clk); photon_evt = 1;
    @(negedge clk); photon_evt = 0;
    if (kind == 1) begin ok_a = 1; ok_b = 1; end
    else if (kind == 2) ok_a = 1;
    @(negedge clk); ok_a = 0; ok_b = 0;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk); rst = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk); rst = 0;
    @(negedge clk);
    chk_state("R9 reset", 0, 0, 0, 0);
    chk("R9 reset ld_a", ld_a, 0);

    // R1: photon events before init are ignored
    for (int i = 0; i < RUN_LEN; i++) attempt(0);
    chk("R1 no init dly_a", dly_a, 0);

    init_done = 1;
    n_lda = 0; n_ldb = 0;
    for (int i = 0; i < NV; i++) begin
      attempt(int'(VEC[i][23:22]));
      chk_state($sformatf("R2/R3/R5/R6/R7 vec%0d", i),
        int'(VEC[i][21:12]), int'(VEC[i][11:2]), int'(VEC[i][1]), int'(VEC[i][0]));
    end
    chk("R6 ld_a pulses", n_lda, LIMIT);
    chk("R6 ld_b pulses", n_ldb, LIMIT);

    // R7: after error nothing moves
    for (int i = 0; i < RUN_LEN; i++) attempt(0);
    chk_state("R7 frozen", LIMIT, LIMIT, 0, 1);

    // R9: reset mid-state
    do_reset();
    chk_state("R9 re-reset", 0, 0, 0, 0);

    // R8: photon during settling is ignored
    for (int i = 0; i < RUN_LEN - 1; i++) attempt(0);
    @(negedge clk); photon_evt = 1;
    @(negedge clk); photon_evt = 0;
    for (int i = 0; i < WAIT_CYC + 4 && !ld_a; i++) @(negedge clk);
    chk("R6 ld_a seen", ld_a, 1);
    photon_evt = 1;
    @(negedge clk); photon_evt = 0;
    repeat (GAP) @(negedge clk);
    chk("R8 step1 dly_a", dly_a, 1);
    for (int i = 0; i < RUN_LEN - 1; i++) attempt(0);
    chk("R8 settle photon ignored", dly_a, 1);
    attempt(0);
    chk("R5 fifth miss steps", dly_a, 2);

    // R4: hit run with a break, then done
    do_reset();
    for (int i = 0; i < RUN_LEN - 1; i++) attempt(1);
    attempt(0);
    for (int i = 0; i < RUN_LEN - 1; i++) attempt(1);
    chk("R5 miss breaks hit run", done, 0);
    attempt(1);
    chk_state("R4 done", 0, 0, 1, 0);
    for (int i = 0; i < RUN_LEN; i++) attempt(0);
    chk_state("R4 frozen after done", 0, 0, 1, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule